// File: doc/BRIEF.md
# Double-Buffered Frame Base Registers

This block holds the start addresses of the frame buffers for the upper and lower panels of a display controller. The lower address matters only when the controller drives a dual panel. Software writes a pending address for each panel through a small register port. The pixel-fetch DMA never reads those pending values directly. It reads a pair of current registers instead, and the block refreshes them from the pending values at each vertical sync. Software can therefore stage the next buffer at any point in a frame without tearing the picture on screen.

Every transfer sets an "updated" flag. If the interrupt mask is set, the same transfer raises an interrupt, so software can load the address of the next buffer at once. The current registers also load when the controller enable rises, so the first frame fetches from valid addresses. For this reason, software must program both addresses before it sets the enable.

Top module: `fb_base_regs`

## Requirements
- R1: After reset, both current addresses, both pending addresses, the mask, the updated flag and the interrupt are all zero.
- R2: A write stores data bits 31:3 in the selected register, and bits 2:0 are dropped. Register offsets are 0 (upper pending), 1 (lower pending), 2 (control, bit 0 = interrupt mask) and 3 (status, bit 0 = updated flag, read-only). Read data is registered: it shows the addressed register as it stood before the clock edge, one cycle after the address is presented. The low three bits of an address read as zero.
- R3: A write to a pending register changes neither current address until a transfer takes place.
- R4: When vsync is high on an edge at which enable is high, each current address takes the value its pending register held before that edge. The new values are visible after that edge.
- R5: A vsync while enable is low causes no transfer and does not set the updated flag.
- R6: On the first edge at which enable is seen high after being low, the current addresses load the pending values. This load does not set the updated flag.
- R7: A transfer sets the updated flag. The flag stays set until an edge with irq_clr_i high. If a transfer and a clear fall on the same edge, the flag ends up set.
- R8: The interrupt output equals the updated flag ANDed with the mask. It changes on the same edge as the flag and the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Controller enable |
| vsync_i | input | 1 | Vertical sync strobe, acted on each cycle it is high |
| wr_en_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset for writes and reads |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| irq_clr_i | input | 1 | Clears the updated flag |
| cur_upper_o | output | 32 | Current upper panel base address |
| cur_lower_o | output | 32 | Current lower panel base address |
| updated_o | output | 1 | New base address updated flag |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bench writes a pending address on the same edge as a vsync. A design that forwarded the write would show the new address one frame early, where the old one belongs. It drives a vsync and a clear together: a design that let the clear win would lose an update event. It pulses vsync with enable low, and raises enable without a vsync. A design that gated wrongly would then either move the current addresses or set the flag where it must not. A long random phase follows. In it, a behavioural model checks every output on every cycle, which catches an interrupt that lags the flag or ignores the mask.

// File: rtl/fbb_pkg.sv
package fbb_pkg;
  localparam int NPANEL   = 2;
  localparam int REG_AW   = 2;
  localparam int OFF_CTRL = NPANEL;
  localparam int OFF_STAT = NPANEL + 1;
endpackage

// File: rtl/fbb_shadow_reg.sv
module fbb_shadow_reg #(
  parameter int W   = 32,
  parameter int LSB = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         load_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] cur_o
);
  localparam int FW = W - LSB;
  logic [FW-1:0] pend_q, cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      cur_q  <= '0;
    end else begin
      if (load_i) cur_q <= pend_q;
      if (wr_i)   pend_q <= wdata_i[W-1:LSB];
    end
  end

  assign pend_o = {pend_q, {LSB{1'b0}}};
  assign cur_o  = {cur_q, {LSB{1'b0}}};

  // R3: without a load the current address holds
  a_r3_hold_midframe: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(cur_o));
  // R4: a load takes the pending value from before the edge
  a_r4_load_pending: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cur_o == $past(pend_o)));
endmodule

// File: rtl/fbb_status.sv
module fbb_status (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_wr_i,
  input  logic mask_d_i,
  output logic flag_o,
  output logic mask_o,
  output logic irq_o
);
  logic flag_d, mask_d;

  always_comb begin
    flag_d = flag_o;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
    mask_d = mask_wr_i ? mask_d_i : mask_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      mask_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      flag_o <= flag_d;
      mask_o <= mask_d;
      irq_o  <= flag_d & mask_d;
    end
  end

  // R7: an event always leaves the flag set
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  // R7: a clear with no event drops the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o);
  // R8: the interrupt follows flag and mask together
  a_r8_irq_masked: assert property (@(posedge clk) disable iff (rst)
    irq_o == (flag_o & mask_o));
endmodule

// File: rtl/fb_base_regs.sv
module fb_base_regs #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en_i,
  input  logic                      vsync_i,
  input  logic                      wr_en_i,
  input  logic [fbb_pkg::REG_AW-1:0] reg_addr_i,
  input  logic [ADDR_W-1:0]         wr_data_i,
  output logic [ADDR_W-1:0]         rd_data_o,
  input  logic                      irq_clr_i,
  output logic [ADDR_W-1:0]         cur_upper_o,
  output logic [ADDR_W-1:0]         cur_lower_o,
  output logic                      updated_o,
  output logic                      irq_o
);
  import fbb_pkg::*;

  logic en_q;
  logic xfer, en_rise, load;
  logic [NPANEL-1:0][ADDR_W-1:0] pend, cur;
  logic mask;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= en_i;
  end

  assign xfer    = en_i & vsync_i;
  assign en_rise = en_i & ~en_q;
  assign load    = xfer | en_rise;

  for (genvar p = 0; p < NPANEL; p++) begin : g_panel
    fbb_shadow_reg #(.W(ADDR_W), .LSB(ALIGN_BITS)) u_shadow (
      .clk     (clk),
      .rst     (rst),
      .wr_i    (wr_en_i && (int'(reg_addr_i) == p)),
      .wdata_i (wr_data_i),
      .load_i  (load),
      .pend_o  (pend[p]),
      .cur_o   (cur[p])
    );
  end

  fbb_status u_status (
    .clk       (clk),
    .rst       (rst),
    .set_i     (xfer),
    .clr_i     (irq_clr_i),
    .mask_wr_i (wr_en_i && (int'(reg_addr_i) == OFF_CTRL)),
    .mask_d_i  (wr_data_i[0]),
    .flag_o    (updated_o),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else begin
      rd_data_o <= '0;
      if (int'(reg_addr_i) < NPANEL)          rd_data_o <= pend[reg_addr_i];
      else if (int'(reg_addr_i) == OFF_CTRL)  rd_data_o[0] <= mask;
      else                                    rd_data_o[0] <= updated_o;
    end
  end

  assign cur_upper_o = cur[0];
  assign cur_lower_o = cur[1];

  // R5: vsync with the enable low leaves the flag alone
  a_r5_idle_vsync: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !irq_clr_i) |=> (updated_o == $past(updated_o)));
  // R6: enable rise loads the upper current from its pending value
  a_r6_enable_load: assert property (@(posedge clk) disable iff (rst)
    (en_i && !en_q) |=> (cur_upper_o == $past(pend[0])));
endmodule

// File: tb/fb_base_regs_tb.sv
module fb_base_regs_tb;
  logic clk = 0, rst = 1, en = 0, vs = 0, we = 0, clr = 0;
  logic [1:0] addr = 0;
  logic [31:0] wd = 0;
  logic [31:0] rd, cu, cl;
  logic upd, irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fb_base_regs u_dut (
    .clk(clk), .rst(rst), .en_i(en), .vsync_i(vs), .wr_en_i(we),
    .reg_addr_i(addr), .wr_data_i(wd), .rd_data_o(rd), .irq_clr_i(clr),
    .cur_upper_o(cu), .cur_lower_o(cl), .updated_o(upd), .irq_o(irq));

  // behavioural reference
  int unsigned m_p[2], m_c[2], m_rd;
  bit m_mask, m_st, m_irq, m_enq;

  always @(posedge clk) begin
    int unsigned op0, op1, ord;
    bit ost, xf, rise;
    if (rst) begin
      m_p = '{0, 0}; m_c = '{0, 0}; m_rd = 0;
      m_mask = 0; m_st = 0; m_irq = 0; m_enq = 0;
    end else begin
      op0 = m_p[0]; op1 = m_p[1]; ost = m_st;
      case (addr)
        0: ord = op0;
        1: ord = op1;
        2: ord = {31'b0, m_mask};
        default: ord = {31'b0, ost};
      endcase
      m_rd = ord;
      xf = en && vs;
      rise = en && !m_enq;
      if (xf || rise) begin m_c[0] = op0; m_c[1] = op1; end
      if (xf) m_st = 1; else if (clr) m_st = 0;
      if (we) begin
        if (addr == 0) m_p[0] = wd & 32'hFFFF_FFF8;
        if (addr == 1) m_p[1] = wd & 32'hFFFF_FFF8;
        if (addr == 2) m_mask = wd[0];
      end
      m_irq = m_st & m_mask;
      m_enq = en;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk("R4 cur_upper", cu, m_c[0]);
    chk("R4 cur_lower", cl, m_c[1]);
    chk("R7 updated", {31'b0, upd}, {31'b0, m_st});
    chk("R8 irq", {31'b0, irq}, {31'b0, m_irq});
    chk("R2 rd_data", rd, m_rd);
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    we = 1; addr = a; wd = d; step(); we = 0;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); step(2); rst = 0; step();
    chk("R1 reset cur_upper", cu, 0);
    chk("R1 reset cur_lower", cl, 0);
    chk("R1 reset flag/irq", {30'b0, upd, irq}, 0);
    wr(0, 32'h1234_567F);
    wr(1, 32'hABCD_EF07);
    addr = 0; step();
    chk("R2 upper readback", rd, 32'h1234_5678);
    addr = 1; step();
    chk("R2 lower readback", rd, 32'hABCD_EF00);
    chk("R3 cur unchanged", cu, 0);
    vs = 1; step(); vs = 0;
    chk("R5 no transfer when disabled", cu, 0);
    chk("R5 no flag when disabled", {31'b0, upd}, 0);
    en = 1; step();
    chk("R6 enable load upper", cu, 32'h1234_5678);
    chk("R6 enable load lower", cl, 32'hABCD_EF00);
    chk("R6 no flag", {31'b0, upd}, 0);
    wr(0, 32'h2000_0000);
    step(3);
    chk("R3 midframe hold", cu, 32'h1234_5678);
    vs = 1; step(); vs = 0;
    chk("R4 vsync transfer", cu, 32'h2000_0000);
    chk("R7 flag set", {31'b0, upd}, 1);
    chk("R8 masked off", {31'b0, irq}, 0);
    clr = 1; step(); clr = 0;
    chk("R7 cleared", {31'b0, upd}, 0);
    wr(2, 1);
    vs = 1; we = 1; addr = 1; wd = 32'h3000_0008; step(); vs = 0; we = 0;
    chk("R4 write with vsync keeps old", cl, 32'hABCD_EF00);
    chk("R8 irq raised", {31'b0, irq}, 1);
    vs = 1; clr = 1; step(); vs = 0; clr = 0;
    chk("R7 set wins over clear", {31'b0, upd}, 1);
    chk("R4 next vsync takes write", cl, 32'h3000_0008);
    for (int i = 0; i < 3000; i++) begin
      en = ($urandom % 16) != 0;
      vs = ($urandom % 8) == 0;
      clr = ($urandom % 6) == 0;
      we = ($urandom % 3) == 0;
      addr = 2'($urandom);
      wd = $urandom;
      step();
    end
    we = 0; vs = 0; clr = 0;
    step();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule